// File: doc/BRIEF.md
# Flash Protected-Range Address Checker

This block stands in front of a serial flash sequencer and decides, for every flash cycle request, whether the cycle may start. It keeps a small bank of protected-range registers. Each one describes an inclusive window of flash addresses with 4 KB granularity, and carries one enable that blocks reads and a separate enable that blocks writes and erases. A request whose address falls inside an enabled window for its direction is refused and reported as a cycle error. Every other request is granted.

Software programs the ranges through a simple register write port. Once the global lock input has been seen high, the bank is frozen and stays frozen until reset. The sequencer offers one request per clock: an address and a direction. One clock later it receives either a grant pulse or an error pulse.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, grant and error are both low and every range is disabled, so every request is granted.
- R2: A range word has bit 31 as its write/erase protect enable, bits 28:16 as the upper limit (address bits 24:12, with low 12 bits taken as 0xFFF) and bits 12:0 as the lower limit (address bits 24:12, with low 12 bits taken as 0x000). A write request inside an enabled window is denied.
- R3: Bit 15 of a range word is its read protect enable. A read request (`req_write`=0) inside an enabled window is denied.
- R4: Protection is per direction. A range with only write protection grants reads, and a range with only read protection grants writes.
- R5: Windows are inclusive. The first byte of the lower page and the last byte of the upper page are denied. The byte just below the window and the byte just above it are granted.
- R6: A range whose upper limit is below its lower limit matches no address.
- R7: Once `lock_i` has been high at a clock edge, register writes are ignored until reset, even after `lock_i` falls. A write issued in the same cycle that `lock_i` is high is also ignored.
- R8: A request presented in cycle t produces exactly one of `grant` or `deny_err`, high for one cycle at t+1. With no request, both stay low.
- R9: A request is denied when any one of the five ranges matches it. The ranges are checked independently.
- R10: Writes to index 5 to 7 change no range. Bits 30:29 and 14:13 of a range word have no effect.
- R11: A register write takes effect for requests from the next cycle onward. A request in the same cycle as the write is checked against the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Global lock; freezes the range bank once seen |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Range register index (0 to 4 valid) |
| cfg_wdata | input | 32 | Range register write data |
| req_valid | input | 1 | Flash cycle request present |
| req_addr | input | 25 | Flash byte address of the request |
| req_write | input | 1 | 1 = write or erase, 0 = read |
| grant | output | 1 | Request allowed (one cycle after request) |
| deny_err | output | 1 | Request blocked, cycle error (one cycle after request) |

## Verification
Directed windows place addresses on the page one below the lower limit, on the lower limit, on the upper limit's last byte, and one byte past it. These cases separate inclusive bounds from exclusive ones and show whether the 4 KB page fill was applied. A range with only one enable is probed with both directions, which shows whether the direction selects the correct enable. An inverted window and writes to unused indices show whether ill-formed settings are ignored. Sequences that toggle the lock show the difference between a level-sensitive freeze and a sticky one. Randomised range words, with reserved bits set, and random addresses and directions are then compared against a bench model over many cycles. This exercises overlapping and multi-range matches.

// File: rtl/frg_pkg.sv
// Package: shared field layout and range record for the flash range guard.
// Assumes a 25-bit flash byte address split into a 13-bit page and 12-bit offset.
package frg_pkg;
    localparam int PAGE_W  = 12;
    localparam int LIM_W   = 13;
    localparam int ADDR_W  = LIM_W + PAGE_W;
    localparam int REG_W   = 32;
    localparam int WP_BIT  = 31;
    localparam int RP_BIT  = 15;
    localparam int HI_LSB  = 16;
    localparam int LO_LSB  = 0;

    typedef struct packed {
        logic             wp;
        logic             rp;
        logic [LIM_W-1:0] hi;
        logic [LIM_W-1:0] lo;
    } range_t;

    // Extract the meaningful fields of a range word; reserved bits drop out.
    function automatic range_t unpack_range(input logic [REG_W-1:0] w);
        range_t r;
        r.wp = w[WP_BIT];
        r.rp = w[RP_BIT];
        r.hi = w[HI_LSB +: LIM_W];
        r.lo = w[LO_LSB +: LIM_W];
        return r;
    endfunction
endpackage

// File: rtl/frg_range_bank.sv
// Range bank: holds the protected-range records and freezes them once the
// lock input has been seen. Assumes writes are single-cycle strobes.
module frg_range_bank
    import frg_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock_i,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic [REG_W-1:0]        cfg_wdata,
    output range_t [NUM_RANGES-1:0] ranges_o
);
    logic   lock_q;
    logic   wr_open;
    logic   idx_ok;
    range_t new_rng;

    // Sticky record that the lock has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else if (lock_i) lock_q <= 1'b1;
    end

    // Qualify a write: not frozen and aimed at an existing range.
    always_comb begin
        idx_ok  = (int'(cfg_idx) < NUM_RANGES);
        wr_open = cfg_we && idx_ok && !lock_i && !lock_q;
        new_rng = unpack_range(cfg_wdata);
    end

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
        // Store one range record when addressed by an open write.
        always_ff @(posedge clk) begin
            if (!rst_n) ranges_o[g] <= '0;
            else if (wr_open && int'(cfg_idx) == g) ranges_o[g] <= new_rng;
        end
    end

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    assert_frozen_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q || lock_i) |=> $stable(ranges_o));
    assert_bad_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !idx_ok) |=> $stable(ranges_o));
endmodule

// File: rtl/frg_window_match.sv
// Window match: decides whether one request hits one range record.
// Assumes limits are page numbers; the window spans lo*4K .. hi*4K+0xFFF.
module frg_window_match
    import frg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  range_t            rng,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              hit
);
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic              en;

    // Expand page limits to byte bounds and compare inclusively.
    always_comb begin
        lo_addr = {rng.lo, {PAGE_W{1'b0}}};
        hi_addr = {rng.hi, {PAGE_W{1'b1}}};
        en      = is_write ? rng.wp : rng.rp;
        hit     = en && (addr >= lo_addr) && (addr <= hi_addr);
    end

    assert_inverted_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rng.hi < rng.lo) |-> !hit);
    assert_hit_in_pages_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (addr[ADDR_W-1:PAGE_W] >= rng.lo) && (addr[ADDR_W-1:PAGE_W] <= rng.hi));
    assert_dir_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (is_write ? rng.wp : rng.rp));
endmodule

// File: rtl/frg_verdict.sv
// Verdict: registers the grant or error pulse one cycle after a request.
// Assumes at most one request per clock.
module frg_verdict (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic any_hit,
    output logic grant,
    output logic deny_err
);
    // Turn the combined match into exactly one registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant    <= 1'b0;
            deny_err <= 1'b0;
        end else begin
            grant    <= req_valid && !any_hit;
            deny_err <= req_valid && any_hit;
        end
    end

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny_err));
    assert_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || deny_err) |-> $past(req_valid));
    assert_answer_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant || deny_err));
endmodule

// File: rtl/flash_range_guard.sv
// Flash range guard top: checks each flash cycle request against the range
// bank and answers grant or cycle error one clock later.
// Assumes the lock source and the flash sequencer live outside this block.
module flash_range_guard
    import frg_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              grant,
    output logic              deny_err
);
    range_t [NUM_RANGES-1:0] ranges;
    logic   [NUM_RANGES-1:0] hit_vec;
    logic                    any_hit;

    frg_range_bank #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .ranges_o(ranges)
    );

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
        frg_window_match u_match (
            .clk(clk), .rst_n(rst_n), .rng(ranges[g]), .addr(req_addr),
            .is_write(req_write), .hit(hit_vec[g])
        );
    end

    // Any matching range blocks the request.
    always_comb any_hit = |hit_vec;

    frg_verdict u_verdict (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .any_hit(any_hit),
        .grant(grant), .deny_err(deny_err)
    );

    assert_deny_has_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deny_err |-> $past(hit_vec != '0));
endmodule

// File: tb/sim_flash_range_guard.sv
module sim_flash_range_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        grant, deny_err;

    int n_chk = 0, n_bad = 0;
    logic [31:0] mreg [5];
    logic        mlock;

    always #2.5 clk = ~clk;

    flash_range_guard u0 (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .grant(grant), .deny_err(deny_err)
    );

    function automatic logic model_hit(logic [24:0] a, logic w);
        logic h = 1'b0;
        for (int i = 0; i < 5; i++) begin
            logic [24:0] lo = {mreg[i][12:0], 12'h000};
            logic [24:0] hi = {mreg[i][28:16], 12'hfff};
            logic en = w ? mreg[i][31] : mreg[i][15];
            if (en && a >= lo && a <= hi) h = 1'b1;
        end
        return h;
    endfunction

    task automatic check(string tag, logic eg, logic ee);
        n_chk++;
        if (grant !== eg || deny_err !== ee) begin
            n_bad++;
            $display("FAIL %s: grant=%b err=%b expected grant=%b err=%b",
                     tag, grant, deny_err, eg, ee);
        end
    endtask

    // One clock: drive at negedge, update model after the edge, check at next negedge.
    task automatic cyc(string tag, logic rv, logic [24:0] a, logic w,
                       logic we = 0, logic [2:0] idx = 0, logic [31:0] d = 0, logic lk = 0);
        logic h;
        req_valid = rv; req_addr = a; req_write = w;
        cfg_we = we; cfg_idx = idx; cfg_wdata = d; lock_i = lk;
        h = model_hit(a, w);
        @(posedge clk); #1;
        if (we && !lk && !mlock && idx < 5) mreg[idx] = d;
        if (lk) mlock = 1'b1;
        @(negedge clk);
        check(tag, rv && !h, rv && h);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 0; cfg_we = 0; lock_i = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) mreg[i] = '0;
        mlock = 1'b0;
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] rw(logic wp, logic rp, logic [12:0] lo, logic [12:0] hi);
        return {wp, 2'b00, hi, rp, 2'b00, lo};
    endfunction

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: timeout actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        check("R1 reset outputs", 1'b0, 1'b0);
        cyc("R1 write after reset", 1, 25'h1abcde, 1);
        cyc("R1 read after reset", 1, 25'h000000, 0);
        cyc("R8 idle", 0, 25'h010000, 1);
        // range 2: write protect pages 0x010..0x020
        cyc("R11 cfg", 1, 25'h015000, 1, 1, 3'd2, rw(1, 0, 13'h010, 13'h020));
        cyc("R2 inside", 1, 25'h015000, 1);
        cyc("R5 lower edge", 1, 25'h010000, 1);
        cyc("R5 below", 1, 25'h00ffff, 1);
        cyc("R5 upper edge", 1, 25'h020fff, 1);
        cyc("R5 above", 1, 25'h021000, 1);
        cyc("R4 read under wp", 1, 25'h015000, 0);
        // range 4: read protect only
        cyc("R3 cfg", 0, 0, 0, 1, 3'd4, rw(0, 1, 13'h100, 13'h100));
        cyc("R3 read denied", 1, 25'h100800, 0);
        cyc("R4 write under rp", 1, 25'h100800, 1);
        // R11: rewrite range 4 to disable while requesting same cycle
        cyc("R11 old value", 1, 25'h100800, 0, 1, 3'd4, 32'h0);
        cyc("R11 new value", 1, 25'h100800, 0);
        // range 0 inverted window
        cyc("R6 cfg", 0, 0, 0, 1, 3'd0, rw(1, 1, 13'h101, 13'h0ff));
        cyc("R6 inverted a", 1, 25'h100000, 1);
        cyc("R6 inverted b", 1, 25'h0ff800, 0);
        // R10: unused indices and reserved bits
        cyc("R10 idx5", 0, 0, 0, 1, 3'd5, 32'hffffffff);
        cyc("R10 idx7", 0, 0, 0, 1, 3'd7, 32'hffffffff);
        cyc("R10 after bad idx", 1, 25'h1fffff, 1);
        cyc("R10 reserved cfg", 0, 0, 0, 1, 3'd1, rw(0, 0, 13'h1ff, 13'h1ff) | 32'h6000_6000);
        cyc("R10 reserved no effect", 1, 25'h1ff000, 1);
        // R9: second range overlapping, any match denies
        cyc("R9 cfg", 0, 0, 0, 1, 3'd3, rw(1, 1, 13'h1f0, 13'h1fff));
        cyc("R9 second range", 1, 25'h1ff000, 0);
        cyc("R9 first range", 1, 25'h012000, 1);
        // R7: lock with simultaneous write, then writes after lock falls
        cyc("R7 lock+write", 0, 0, 0, 1, 3'd1, rw(1, 1, 13'h000, 13'h00f), 1);
        cyc("R7 write after lock", 0, 0, 0, 1, 3'd1, rw(1, 1, 13'h000, 13'h00f), 0);
        cyc("R7 frozen", 1, 25'h000100, 1);
        cyc("R7 frozen clear", 0, 0, 0, 1, 3'd2, 32'h0);
        cyc("R7 old range kept", 1, 25'h015000, 1);
        do_reset();
        cyc("R7 reset unfreezes", 0, 0, 0, 1, 3'd1, rw(1, 1, 13'h000, 13'h00f));
        cyc("R7 write took", 1, 25'h000100, 1);
        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] d = $urandom;
            logic [24:0] a = 25'($urandom);
            logic we = ($urandom % 8) == 0;
            logic lk = ($urandom % 1000) == 0;
            if (($urandom % 500) == 0) do_reset();
            cyc("R9 random", ($urandom % 4) != 0, a, 1'($urandom), we,
                3'($urandom), d, lk);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule